// File: doc/BRIEF.md
# Multi-Page-Size Translation Match Array

This block is a small fully associative address translation cache. Each slot holds a translation for one page of virtual memory. Slot fields: the virtual page number, a two-bit page size code, a security-world tag, a global flag or an 8-bit address-space identifier, the physical page number and a byte of memory attributes. The page size code sets how many low address bits drop out of the tag compare and pass straight through from the virtual to the physical address.

A lookup presents a 32-bit virtual address, the current address-space identifier and the requester's security state. One cycle later the block returns hit or miss. On a hit it also returns the merged physical address, the attributes and the slot index. Slots are filled one per write through a round-robin pointer. Two invalidate controls remove entries: one clears everything, the other clears only the non-global entries of one address space.

Top module: `tlb_match_array`

## Requirements
- R1: After reset every slot is invalid, the fill pointer is at slot 0, and `rsp_valid` and `rsp_hit` are low.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high. The response reflects slot contents as they stood before any write on that same edge.
- R3: Page size code 0 is 4 KB, 1 is 64 KB, 2 is 1 MB and 3 is 16 MB. The tag compare covers virtual address bits [31:12], [31:16], [31:20] or [31:24] respectively.
- R4: On a hit, physical address bits at and above the page size come from the slot's physical page. The bits below come from the request's virtual address. Stored physical page bits below the page size are ignored.
- R5: A slot hits only when its security tag (1 = non-secure) equals `lk_nonsec`.
- R6: A slot hits when its global flag is set, or when its stored identifier equals `lk_asid`.
- R7: On a miss, `rsp_hit`, `rsp_paddr`, `rsp_attr` and `rsp_index` are all zero.
- R8: Each write fills the slot at the fill pointer and marks it valid. The pointer then advances by one and wraps from the last slot to slot 0. A hit reports the slot number on `rsp_index`.
- R9: `inv_all` makes every slot invalid from the next edge on.
- R10: `inv_asid_en` invalidates only the slots that are non-global and whose identifier equals `inv_asid`. Global slots and other identifiers stay valid.
- R11: When a write and an invalidate share an edge, the written slot ends up valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_nonsec | input | 1 | Requester security state, 1 = non-secure |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A slot matched |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_attr | output | 8 | Memory attributes of the matching slot |
| rsp_index | output | 3 | Index of the matching slot |
| wr_en | input | 1 | Fill the slot at the round-robin pointer |
| wr_vpn | input | 20 | Virtual page number (address bits 31:12) |
| wr_size | input | 2 | Page size code |
| wr_nonsec | input | 1 | Security tag of the new slot |
| wr_global | input | 1 | Global flag of the new slot |
| wr_asid | input | 8 | Identifier of the new slot |
| wr_ppn | input | 20 | Physical page number (address bits 31:12) |
| wr_attr | input | 8 | Memory attributes of the new slot |
| inv_all | input | 1 | Invalidate every slot |
| inv_asid_en | input | 1 | Invalidate non-global slots with a given identifier |
| inv_asid | input | 8 | Identifier for the selective invalidate |

## Verification
The assertions assume `lk_req` is held low while reset is asserted, so the first response after reset lines up with a real request. They also assume that no two valid slots ever match the same lookup, since only the lowest index would be reported. The stimulus gives every filled page a distinct address range within its security world and identifier. It drives only idle inputs during reset, and it never stacks an invalidate onto a lookup that the flush assertion watches without also leaving the write enable low.

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [31:0]       lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_nonsec,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_paddr,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [IDX_W-1:0]  rsp_index,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [1:0]        wr_size,
  input  logic              wr_nonsec,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_ppn,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic [ASID_W-1:0] inv_asid
);

  function automatic logic [VPN_W-1:0] keep_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    keep_mask = 20'hFFFFF;
      2'd1:    keep_mask = 20'hFFFF0;
      2'd2:    keep_mask = 20'hFFF00;
      default: keep_mask = 20'hFF000;
    endcase
  endfunction

  logic [ENTRIES-1:0] e_valid, e_ns, e_global, hit_vec;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [VPN_W-1:0]   e_ppn  [ENTRIES];
  logic [1:0]         e_size [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [ATTR_W-1:0]  e_attr [ENTRIES];
  logic [IDX_W-1:0]   wr_ptr, sel;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[31:12];

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_ptr <= '0;
    else if (wr_en)
      wr_ptr <= (wr_ptr == IDX_W'(ENTRIES-1)) ? '0 : wr_ptr + 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    wire take = wr_en && (wr_ptr == IDX_W'(i));
    wire kill = inv_all || (inv_asid_en && !e_global[i] && e_asid[i] == inv_asid);

    always_ff @(posedge clk) begin
      if (!rst_n)
        e_valid[i] <= 1'b0;
      else if (take)
        e_valid[i] <= 1'b1;
      else if (kill)
        e_valid[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        e_vpn[i]    <= wr_vpn;
        e_ppn[i]    <= wr_ppn;
        e_size[i]   <= wr_size;
        e_ns[i]     <= wr_nonsec;
        e_global[i] <= wr_global;
        e_asid[i]   <= wr_asid;
        e_attr[i]   <= wr_attr;
      end
    end

    assign hit_vec[i] = e_valid[i]
                     && (e_ns[i] == lk_nonsec)
                     && (e_global[i] || e_asid[i] == lk_asid)
                     && (((e_vpn[i] ^ lk_vpn) & keep_mask(e_size[i])) == '0);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = IDX_W'(i);
  end

  wire [VPN_W-1:0] sel_keep = keep_mask(e_size[sel]);
  wire [31:0] merged = {(e_ppn[sel] & sel_keep) | (lk_vpn & ~sel_keep), lk_vaddr[11:0]};
  wire any_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_attr  <= '0;
      rsp_index <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && any_hit;
      rsp_paddr <= (lk_req && any_hit) ? merged : '0;
      rsp_attr  <= (lk_req && any_hit) ? e_attr[sel] : '0;
      rsp_index <= (lk_req && any_hit) ? sel : '0;
    end
  end

endmodule

module tlb_match_array_chk #(
  parameter int ATTR_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic [31:0]       lk_vaddr,
  input logic              wr_en,
  input logic              inv_all,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [31:0]       rsp_paddr,
  input logic [ATTR_W-1:0] rsp_attr,
  input logic [IDX_W-1:0]  rsp_index
);

  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(lk_req));

  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r4_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req ##1 rsp_hit) |-> rsp_paddr[11:0] == $past(lk_vaddr[11:0]));

  a_r7_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0 && rsp_attr == '0 && rsp_index == '0));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !wr_en) ##1 (lk_req && !wr_en) |=> !rsp_hit);

endmodule

bind tlb_match_array tlb_match_array_chk #(.ATTR_W(ATTR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
  .wr_en(wr_en), .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .rsp_index(rsp_index));

// File: tb/tlb_match_array_test.sv
`timescale 1ns/1ps
module tlb_match_array_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0, lk_nonsec = 0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0] lk_asid = '0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr;
  logic [7:0] rsp_attr;
  logic [2:0] rsp_index;
  logic wr_en = 0, wr_nonsec = 0, wr_global = 0, inv_all = 0, inv_asid_en = 0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [1:0] wr_size = '0;
  logic [7:0] wr_asid = '0, wr_attr = '0, inv_asid = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_match_array uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(logic [19:0] vpn, logic [1:0] sz, logic ns, logic gl,
                      logic [7:0] asid, logic [19:0] ppn, logic [7:0] attr);
    @(negedge clk);
    wr_en = 1; wr_vpn = vpn; wr_size = sz; wr_nonsec = ns; wr_global = gl;
    wr_asid = asid; wr_ppn = ppn; wr_attr = attr;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(string req, logic [31:0] va, logic [7:0] asid, logic ns,
                      logic hit, logic [31:0] pa, logic [7:0] attr, logic [2:0] idx);
    @(negedge clk);
    lk_req = 1; lk_vaddr = va; lk_asid = asid; lk_nonsec = ns;
    @(negedge clk);
    lk_req = 0;
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"}, 32'(rsp_hit), 32'(hit));
    chk({req, " paddr"}, rsp_paddr, hit ? pa : 32'd0);
    chk({req, " attr"}, 32'(rsp_attr), hit ? 32'(attr) : 32'd0);
    chk({req, " index"}, 32'(rsp_index), hit ? 32'(idx) : 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 32'(rsp_valid), 0);
    chk("R1 hit after reset", 32'(rsp_hit), 0);
    look("R1 R7 empty miss", 32'h1234_5678, 8'h05, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2 idle no valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_sizes;
    fill(20'h12345, 2'd0, 0, 0, 8'h05, 20'hABCDE, 8'h11);
    look("R4 R8 4K hit", 32'h1234_5678, 8'h05, 0, 1, 32'hABCD_E678, 8'h11, 3'd0);
    look("R3 4K next page", 32'h1234_6678, 8'h05, 0, 0, 0, 0, 0);
    look("R6 wrong asid", 32'h1234_5678, 8'h06, 0, 0, 0, 0, 0);
    look("R5 wrong world", 32'h1234_5678, 8'h05, 1, 0, 0, 0, 0);
    fill(20'h20000, 2'd1, 1, 1, 8'h00, 20'h30000, 8'h22);
    look("R6 R3 64K global", 32'h2000_ABCD, 8'h77, 1, 1, 32'h3000_ABCD, 8'h22, 3'd1);
    look("R5 secure vs ns", 32'h2000_ABCD, 8'h77, 0, 0, 0, 0, 0);
    look("R3 64K beyond", 32'h2001_0000, 8'h77, 1, 0, 0, 0, 0);
    fill(20'h40000, 2'd2, 0, 0, 8'h09, 20'h5A0FF, 8'h33);
    look("R4 1M merge", 32'h400F_1234, 8'h09, 0, 1, 32'h5A0F_1234, 8'h33, 3'd2);
    look("R3 1M beyond", 32'h4010_0000, 8'h09, 0, 0, 0, 0, 0);
    fill(20'h8F7F0, 2'd3, 0, 1, 8'h09, 20'hC0000, 8'h44);
    look("R3 R4 16M", 32'h8FAB_CDEF, 8'h01, 0, 1, 32'hC0AB_CDEF, 8'h44, 3'd3);
    look("R3 16M beyond", 32'h9000_0000, 8'h01, 0, 0, 0, 0, 0);
  endtask

  task automatic t_inv_asid;
    @(negedge clk);
    inv_asid_en = 1; inv_asid = 8'h09;
    @(negedge clk);
    inv_asid_en = 0;
    look("R10 asid slot gone", 32'h400F_1234, 8'h09, 0, 0, 0, 0, 0);
    look("R10 global kept", 32'h8FAB_CDEF, 8'h09, 0, 1, 32'hC0AB_CDEF, 8'h44, 3'd3);
    look("R10 other asid kept", 32'h1234_5678, 8'h05, 0, 1, 32'hABCD_E678, 8'h11, 3'd0);
  endtask

  task automatic t_flush_with_write;
    @(negedge clk);
    inv_all = 1; wr_en = 1; wr_vpn = 20'h60000; wr_size = 0; wr_nonsec = 0;
    wr_global = 0; wr_asid = 8'h01; wr_ppn = 20'h00777; wr_attr = 8'h55;
    @(negedge clk);
    inv_all = 0; wr_en = 0;
    look("R9 flushed", 32'h1234_5678, 8'h05, 0, 0, 0, 0, 0);
    look("R9 global flushed", 32'h8FAB_CDEF, 8'h01, 0, 0, 0, 0, 0);
    look("R11 write wins", 32'h6000_0ABC, 8'h01, 0, 1, 32'h0077_7ABC, 8'h55, 3'd4);
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 4; i++)
      fill(20'h70000 + 20'(i), 2'd0, 0, 0, 8'h01, 20'h01000 + 20'(i), 8'(8'h60 + i));
    look("R8 wrap to slot0", 32'h7000_3010, 8'h01, 0, 1, 32'h0100_3010, 8'h63, 3'd0);
    look("R8 slot5", 32'h7000_0020, 8'h01, 0, 1, 32'h0100_0020, 8'h60, 3'd5);
    look("R8 slot7", 32'h7000_2000, 8'h01, 0, 1, 32'h0100_2000, 8'h62, 3'd7);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    lk_req = 1; lk_vaddr = 32'hA000_0000; lk_asid = 8'h01; lk_nonsec = 0;
    wr_en = 1; wr_vpn = 20'hA0000; wr_size = 0; wr_nonsec = 0; wr_global = 0;
    wr_asid = 8'h01; wr_ppn = 20'hB0000; wr_attr = 8'h77;
    @(negedge clk);
    lk_req = 0; wr_en = 0;
    chk("R2 same-edge write unseen", 32'(rsp_hit), 0);
    look("R2 R8 visible after", 32'hA000_0004, 8'h01, 0, 1, 32'hB000_0004, 8'h77, 3'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sizes();
    t_inv_asid();
    t_flush_with_write();
    t_round_robin();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule